// File: doc/BRIEF.md
# Codirectional 64 kbit/s Line Encoder

This block takes one octet per frame out of a 2.048 Mbit/s PCM time-slot and turns it into a continuous 64 kbit/s codirectional line signal. The signal is driven on two active-low rails, positive and negative. Capture runs on the PCM bit clock. Line output runs on an unrelated 256 kHz clock, where each data bit takes four line-clock periods (chips).

The serial input works as a stream with no back-pressure. The selected time-slot strobe acts as the valid qualifier, one bit per PCM clock. There is no ready: the encoder always accepts. If the line side has not yet taken the octet it is holding, the newer octet overwrites it. A toggle flag carries each completed octet into the line domain through a two-flop synchronizer.

At every octet boundary the line side does one of three things:
- it loads a fresh octet;
- it sends the previous octet once more;
- it goes quiet.

Mark polarity alternates from one bit block to the next. The last block of each octet deliberately repeats the polarity of the block before it, which marks the octet edge. An alarm input suppresses that violation.

Top module: `cdl_codir_encoder`

## Requirements
- R1: `ts_pick` high selects strobe `ts_a` and low selects `ts_b`; a burst on the unselected strobe is ignored and changes nothing on the rails.
- R2: While the selected strobe is high, `pcm_in` is sampled on each rising `pcm_clk` edge; the eight samples form one octet, the first sample is bit 0, and bit 0 is sent first on the line.
- R3: Each bit fills four line-clock chips; a 1 is marked in chips 0 and 1, a 0 in chips 0 and 2; an unmarked chip leaves both rails high and a marked chip pulls exactly one rail low.
- R4: Successive sent blocks within an octet and across octet boundaries alternate polarity (positive rail, then negative rail).
- R5: The block for bit 7 uses the same polarity as the block for bit 6 (octet-marking violation).
- R6: While `alarm_in` is high, the bit-7 block alternates like any other block, so no violation is sent.
- R7: During and after reset both rails are high, the first block ever sent is positive, and nothing is pending, so the first 32 line clocks are quiet.
- R8: The octet on the line changes only at an octet boundary; an octet captured mid-octet does not disturb the one being sent.
- R9: With nothing new at a boundary, the last octet is sent exactly once more; after that both rails stay high until a new octet arrives.
- R10: Two octets captured before one boundary leave only the second one to be sent; the first is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pcm_clk | input | 1 | PCM bit clock (capture domain) |
| pcm_rst_n | input | 1 | Asynchronous active-low reset, capture domain |
| ts_a | input | 1 | Time-slot strobe A |
| ts_b | input | 1 | Time-slot strobe B |
| ts_pick | input | 1 | Strobe select: 1 = A, 0 = B |
| pcm_in | input | 1 | Serial PCM data |
| line_clk | input | 1 | Line chip clock (four chips per bit) |
| line_rst_n | input | 1 | Asynchronous active-low reset, line domain |
| alarm_in | input | 1 | High suppresses the octet violation |
| rail_pos_n | output | 1 | Positive-polarity mark, active low |
| rail_neg_n | output | 1 | Negative-polarity mark, active low |

## Verification
The rails are decoded from line-domain registers, so each chip is valid one line-clock edge after the state advances. The bench compares the rails against its own model at every falling edge of `line_clk`.

A captured octet becomes visible to the line side about three line clocks after its eighth sample: two synchronizer flops and then edge detection. It can only take effect at the next octet boundary. The bench therefore writes octets at the start of bit 1, which leaves more than 25 line clocks of margin before any transfer decision. Alarm changes are also made early in an octet, so the synchronized value has settled well before the bit-6 to bit-7 decision.

// File: rtl/cdl_pkg.sv
`timescale 1ns/1ps
package cdl_pkg;
  localparam int OCTET_W = 8;
  localparam int CHIPS_PER_BIT = 4;
  localparam int SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    OM_IDLE   = 2'd0,
    OM_FRESH  = 2'd1,
    OM_REPEAT = 2'd2
  } omode_t;
endpackage

// File: rtl/cdl_sync.sv
`timescale 1ns/1ps
module cdl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] s_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= '0;
    else        s_q <= {s_q[STAGES-2:0], d};
  end

  assign q = s_q[STAGES-1];
endmodule

// File: rtl/cdl_slot_capture.sv
`timescale 1ns/1ps
module cdl_slot_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ts_a,
  input  logic         ts_b,
  input  logic         ts_pick,
  input  logic         din,
  output logic [W-1:0] latch_q,
  output logic         req_q
);
  localparam int CW = $clog2(W);

  logic          strobe;
  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;

  assign strobe = ts_pick ? ts_a : ts_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      latch_q <= '0;
      req_q   <= 1'b0;
    end else if (strobe) begin
      sh_q[cnt_q] <= din;
      if (cnt_q == CW'(W-1)) begin
        // complete octet: overwrite the holding latch and flag it
        latch_q <= {din, sh_q[W-2:0]};
        req_q   <= ~req_q;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/cdl_line_coder.sv
`timescale 1ns/1ps
module cdl_line_coder
  import cdl_pkg::*;
#(
  parameter int W     = 8,
  parameter int CHIPS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_s,
  input  logic                     alarm_s,
  input  logic [W-1:0]             latch_d,
  output logic                     rail_pos_n,
  output logic                     rail_neg_n,
  output logic [$clog2(CHIPS)-1:0] chip_o,
  output logic [$clog2(W)-1:0]     bit_o,
  output logic                     send_o,
  output logic                     pol_o,
  output logic [W-1:0]             oreg_o
);
  localparam int CHW = $clog2(CHIPS);
  localparam int BW  = $clog2(W);

  logic [CHW-1:0] chip_q;
  logic [BW-1:0]  bit_q;
  omode_t         mode_q;
  logic           pol_q;
  logic [W-1:0]   oreg_q;
  logic           pend_q;
  logic           req_prev_q;

  logic req_edge, block_end, octet_end, sending, cur_bit, mark;

  assign req_edge  = req_s ^ req_prev_q;
  assign block_end = (chip_q == CHW'(CHIPS-1));
  assign octet_end = block_end && (bit_q == BW'(W-1));
  assign sending   = (mode_q != OM_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip_q     <= '0;
      bit_q      <= '0;
      mode_q     <= OM_IDLE;
      pol_q      <= 1'b1;
      oreg_q     <= '0;
      pend_q     <= 1'b0;
      req_prev_q <= 1'b0;
    end else begin
      req_prev_q <= req_s;
      chip_q     <= block_end ? '0 : chip_q + 1'b1;
      if (block_end) begin
        bit_q <= octet_end ? '0 : bit_q + 1'b1;
        if (sending) begin
          // keep polarity into the last block unless alarm is active
          if (!(bit_q == BW'(W-2) && !alarm_s)) pol_q <= ~pol_q;
        end
      end
      if (octet_end) begin
        if (pend_q || req_edge) begin
          oreg_q <= latch_d;
          mode_q <= OM_FRESH;
          pend_q <= 1'b0;
        end else if (mode_q == OM_FRESH) begin
          mode_q <= OM_REPEAT;
        end else begin
          mode_q <= OM_IDLE;
        end
      end else if (req_edge) begin
        pend_q <= 1'b1;
      end
    end
  end

  always_comb begin
    cur_bit    = oreg_q[bit_q];
    mark       = sending && (cur_bit ? (chip_q < CHW'(CHIPS/2)) : !chip_q[0]);
    rail_pos_n = !(mark && pol_q);
    rail_neg_n = !(mark && !pol_q);
  end

  assign chip_o = chip_q;
  assign bit_o  = bit_q;
  assign send_o = sending;
  assign pol_o  = pol_q;
  assign oreg_o = oreg_q;
endmodule

// File: rtl/cdl_codir_encoder.sv
`timescale 1ns/1ps
module cdl_codir_encoder
  import cdl_pkg::*;
(
  input  logic pcm_clk,
  input  logic pcm_rst_n,
  input  logic ts_a,
  input  logic ts_b,
  input  logic ts_pick,
  input  logic pcm_in,
  input  logic line_clk,
  input  logic line_rst_n,
  input  logic alarm_in,
  output logic rail_pos_n,
  output logic rail_neg_n
);
  localparam int CHW = $clog2(CHIPS_PER_BIT);
  localparam int BW  = $clog2(OCTET_W);

  logic [OCTET_W-1:0] latch_w;
  logic               req_w;
  logic               req_s_w;
  logic               alarm_s_w;
  logic [CHW-1:0]     chip_w;
  logic [BW-1:0]      bit_w;
  logic               send_w;
  logic               pol_w;
  logic [OCTET_W-1:0] oreg_w;

  cdl_slot_capture #(.W(OCTET_W)) u_cap (
    .clk(pcm_clk), .rst_n(pcm_rst_n), .ts_a(ts_a), .ts_b(ts_b),
    .ts_pick(ts_pick), .din(pcm_in), .latch_q(latch_w), .req_q(req_w)
  );

  cdl_sync #(.STAGES(SYNC_DEPTH)) u_req_sync (
    .clk(line_clk), .rst_n(line_rst_n), .d(req_w), .q(req_s_w)
  );

  cdl_sync #(.STAGES(SYNC_DEPTH)) u_alarm_sync (
    .clk(line_clk), .rst_n(line_rst_n), .d(alarm_in), .q(alarm_s_w)
  );

  cdl_line_coder #(.W(OCTET_W), .CHIPS(CHIPS_PER_BIT)) u_coder (
    .clk(line_clk), .rst_n(line_rst_n), .req_s(req_s_w), .alarm_s(alarm_s_w),
    .latch_d(latch_w), .rail_pos_n(rail_pos_n), .rail_neg_n(rail_neg_n),
    .chip_o(chip_w), .bit_o(bit_w), .send_o(send_w), .pol_o(pol_w),
    .oreg_o(oreg_w)
  );
endmodule

// File: rtl/cdl_codir_encoder_chk.sv
`timescale 1ns/1ps
module cdl_codir_encoder_chk #(
  parameter int W     = 8,
  parameter int CHIPS = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [$clog2(CHIPS)-1:0] chip,
  input logic [$clog2(W)-1:0]     bitn,
  input logic                     send,
  input logic                     pol,
  input logic                     alarm_s,
  input logic [W-1:0]             oreg,
  input logic                     rail_pos_n,
  input logic                     rail_neg_n
);
  localparam int CHW = $clog2(CHIPS);
  localparam int BW  = $clog2(W);

  // R3
  last_chip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip == CHW'(CHIPS-1)) |-> (rail_pos_n && rail_neg_n));

  // R3
  block_opens_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (send && chip == '0) |-> (rail_pos_n != rail_neg_n));

  // R7
  idle_rails_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !send |-> (rail_pos_n && rail_neg_n));

  // R4
  alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (send && chip == CHW'(CHIPS-1) && bitn != BW'(W-2)) |=> (pol != $past(pol)));

  // R5
  octet_violation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (send && chip == CHW'(CHIPS-1) && bitn == BW'(W-2) && !alarm_s) |=> $stable(pol));

  // R6
  alarm_no_violation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (send && chip == CHW'(CHIPS-1) && bitn == BW'(W-2) && alarm_s) |=> (pol != $past(pol)));

  // R8
  octet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(chip == CHW'(CHIPS-1) && bitn == BW'(W-1)) |=> $stable(oreg));
endmodule

bind cdl_codir_encoder cdl_codir_encoder_chk #(.W(OCTET_W), .CHIPS(CHIPS_PER_BIT)) u_chk (
  .clk(line_clk), .rst_n(line_rst_n), .chip(chip_w), .bitn(bit_w),
  .send(send_w), .pol(pol_w), .alarm_s(alarm_s_w), .oreg(oreg_w),
  .rail_pos_n(rail_pos_n), .rail_neg_n(rail_neg_n)
);

// File: tb/tb_cdl_codir_encoder.sv
`timescale 1ns/1ps
module tb_cdl_codir_encoder;
  logic pcm_clk = 1'b0;
  logic line_clk = 1'b0;
  logic pcm_rst_n = 1'b0, line_rst_n = 1'b0;
  logic ts_a = 1'b0, ts_b = 1'b0, ts_pick = 1'b1, pcm_in = 1'b0, alarm_in = 1'b0;
  logic rail_pos_n, rail_neg_n;

  always #2.5 pcm_clk = ~pcm_clk;
  always #20  line_clk = ~line_clk;

  cdl_codir_encoder dut (
    .pcm_clk(pcm_clk), .pcm_rst_n(pcm_rst_n), .ts_a(ts_a), .ts_b(ts_b),
    .ts_pick(ts_pick), .pcm_in(pcm_in), .line_clk(line_clk),
    .line_rst_n(line_rst_n), .alarm_in(alarm_in),
    .rail_pos_n(rail_pos_n), .rail_neg_n(rail_neg_n)
  );

  int    checks = 0;
  int    fails = 0;
  string tag = "R7";
  bit    finished = 1'b0;

  // behavioural reference: position in octet (0..31), plus what is on air
  int         pos = 0;
  bit         m_pol = 1'b1;
  bit         m_send = 1'b0;
  bit         m_again = 1'b0;
  bit         m_pend = 1'b0;
  logic [7:0] m_data = 8'h00;
  logic [7:0] m_latch = 8'h00;

  always @(posedge line_clk) begin
    if (!line_rst_n) begin
      pos = 0; m_pol = 1'b1; m_send = 1'b0; m_again = 1'b0; m_pend = 1'b0;
    end else begin
      if ((pos % 4) == 3 && m_send) begin
        int nb;
        nb = (pos / 4 + 1) % 8;
        if (!(nb == 7 && !alarm_in)) m_pol = !m_pol;
      end
      if (pos == 31) begin
        if (m_pend) begin
          m_data = m_latch; m_send = 1'b1; m_again = 1'b1; m_pend = 1'b0;
        end else if (m_again) begin
          m_send = 1'b1; m_again = 1'b0;
        end else begin
          m_send = 1'b0;
        end
      end
      pos = (pos + 1) % 32;
    end
  end

  always @(negedge line_clk) begin
    if (!finished) begin
      int  chip, bi;
      bit  mark, ep, en;
      chip = pos % 4;
      bi   = pos / 4;
      mark = m_send && (m_data[bi] ? (chip < 2) : ((chip % 2) == 0));
      ep   = !(mark && m_pol);
      en   = !(mark && !m_pol);
      checks++;
      if (rail_pos_n !== ep || rail_neg_n !== en) begin
        fails++;
        $display("FAIL %s: pos=%0d rails actual %b%b expected %b%b",
                 tag, pos, rail_pos_n, rail_neg_n, ep, en);
      end
    end
  end

  task automatic wait_pos(input int p);
    do @(negedge line_clk); while (pos != p);
  endtask

  task automatic slot(input bit on_a, input logic [7:0] d);
    @(negedge pcm_clk);
    if (on_a) ts_a = 1'b1; else ts_b = 1'b1;
    pcm_in = d[0];
    for (int i = 1; i < 8; i++) begin
      @(negedge pcm_clk);
      pcm_in = d[i];
    end
    @(negedge pcm_clk);
    ts_a = 1'b0; ts_b = 1'b0; pcm_in = 1'b0;
    if (on_a == ts_pick) begin
      m_latch = d;
      m_pend  = 1'b1;
    end
  endtask

  task automatic send_octet(input bit on_a, input logic [7:0] d);
    wait_pos(4);
    slot(on_a, d);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++;
      $display("FAIL %s: watchdog actual timeout expected completion", tag);
      summary();
      $finish;
    end
  end

  initial begin
    // R7: reset and the first quiet octet
    repeat (3) @(negedge line_clk);
    pcm_rst_n = 1'b1;
    line_rst_n = 1'b1;
    repeat (40) @(negedge line_clk);

    // R2: capture order and first transmission (bit 0 first, positive first)
    tag = "R2";
    send_octet(1'b1, 8'hA5);
    // R3: all-zero and all-one octets exercise both chip patterns
    tag = "R3";
    send_octet(1'b1, 8'h00);
    send_octet(1'b1, 8'hFF);
    // R4: alternation across blocks and boundaries
    tag = "R4";
    send_octet(1'b1, 8'h3C);
    // R5: violation on the last block
    tag = "R5";
    send_octet(1'b1, 8'h81);
    send_octet(1'b1, 8'h42);
    // R6: alarm suppresses the violation
    tag = "R6";
    alarm_in = 1'b1;
    send_octet(1'b1, 8'h96);
    send_octet(1'b1, 8'h5A);
    send_octet(1'b1, 8'h0F);
    wait_pos(6);
    alarm_in = 1'b0;
    // R1: unselected strobe ignored, selected strobe taken
    tag = "R1";
    ts_pick = 1'b0;
    send_octet(1'b1, 8'hC3);
    send_octet(1'b1, 8'h3E);
    send_octet(1'b0, 8'h17);
    // R10: overwrite before the boundary keeps only the newer octet
    tag = "R10";
    wait_pos(4);
    slot(1'b0, 8'hE1);
    wait_pos(16);
    slot(1'b0, 8'h2B);
    // R8: octet captured mid-octet waits for the boundary
    tag = "R8";
    send_octet(1'b0, 8'h69);
    wait_pos(20);
    slot(1'b0, 8'hB4);
    // R9: one repeat, then quiet rails
    tag = "R9";
    repeat (130) @(negedge line_clk);

    summary();
    $finish;
  end
endmodule